// File: doc/BRIEF.md
# Reed-Solomon Frame Encoder with Symbol Interleaving

This block turns 128-bit payload words into short forward-error-corrected frames for a lossy serial lane. A two-bit sync header is placed in front of each payload, chosen by a one-bit block-type input. The 130 bits then split into 26 five-bit symbols. Four Reed-Solomon parity symbols over GF(2^5) are added after the data symbols, which gives a 30-symbol, 150-bit systematic codeword that can correct two symbol errors.

Long error bursts after a decision-feedback equalizer can damage three neighbouring symbols, and that is more than one codeword can correct. To spread such bursts, the block can gather a group of two or three codewords. It then sends their symbols round-robin, so that neighbouring line symbols belong to different codewords. The interleaved group leaves the block as two or three consecutive 150-bit frames. The payload side and the frame side each use a valid/ready handshake. Parity is computed one symbol per clock, so the block takes one payload about every 31 cycles plus the output time.

Top module: `rsenc_frame_enc`

## Requirements
- R1: The two header bits are placed in frame bits [149:148]. They are 2'b10 when `in_btype` is 1 and 2'b01 when it is 0, so the header is never 00 or 11.
- R2: Codeword symbol i (i = 0..29) occupies frame bits [149-5i -: 5]. Symbols 0..25 hold {header, payload}, with the header first, so frame bits [149:20] equal {header, in_payload}.
- R3: Symbols 26..29 are the parity of a systematic RS(30,26) code. The field polynomial is x^5+x^2+1 and the generator roots are α^0..α^3. Symbol 0 is the highest-degree coefficient, so the codeword polynomial evaluates to zero at α^0, α^1, α^2 and α^3.
- R4: With depth 1 (`cfg_depth` 0 or 1), each payload yields one frame equal to its codeword, and frames leave in payload order.
- R5: With depth 2 (`cfg_depth` = 2), the group's 60 line symbols are numbered k = 0..59, and line symbol k is symbol k/2 of codeword k mod 2. The symbols are cut into 2 frames of 30 in order, and line symbol 30f+j goes to frame f at position j, in the R2 layout.
- R6: With depth 3 (`cfg_depth` = 3), line symbol k of 90 is symbol k/3 of codeword k mod 3, cut into 3 frames in the same way. Any three consecutive line symbols therefore come from three different codewords.
- R7: No frame of a group is presented until all codewords of that group have been accepted and encoded.
- R8: The depth is taken from `cfg_depth` when the first payload of a group is accepted. Changes while a group is being filled have no effect until the next group.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_frame` is held unchanged. A payload is taken only in a cycle with `in_valid` and `in_ready` both high.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.
- R11: Under output back-pressure, every accepted payload appears in exactly one group of frames, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Block can take a payload |
| in_payload | input | 128 | Payload data |
| in_btype | input | 1 | Block type, selects the header value |
| cfg_depth | input | 2 | Interleave depth: 2 or 3, any other value means none |
| out_valid | output | 1 | Frame presented |
| out_ready | input | 1 | Sink takes the frame |
| out_frame | output | 150 | Frame, first line symbol in the top bits |

## Verification
The patterns are all-zero and all-one payloads, which separate header placement from parity arithmetic; a single set bit, which exposes misplaced symbol boundaries; and random payloads with both block types, which exercise the general parity. Two- and three-way groups run with a stalling sink, so the round-robin order and the frame holding are tested under back-pressure. The bench also changes the depth in the middle of a group, which tells a depth latched at the group start from one that follows the input. It also waits with a partial group pending, which shows whether any frame leaves early. For plain frames the bench also evaluates the received codeword at the four generator roots, a check that does not depend on the bench's own encoder.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;

    localparam int SYMW  = 5;
    localparam int KSYM  = 26;
    localparam int NPAR  = 4;
    localparam int NSYM  = KSYM + NPAR;
    localparam int PAYW  = 128;
    localparam int HDRW  = 2;
    localparam int BLKW  = PAYW + HDRW;
    localparam int FRMW  = NSYM * SYMW;
    localparam int MAXD  = 3;
    localparam int IDXW  = $clog2(NSYM);
    localparam int CWW   = $clog2(MAXD + 1);
    localparam int PIDXW = $clog2(NPAR);

    // low terms of the field polynomial x^5 + x^2 + 1
    localparam logic [SYMW-1:0] FLD_LOW = 5'b00101;

    typedef logic [SYMW-1:0]          sym_t;
    typedef logic [NPAR:0][SYMW-1:0]  gen_t;
    typedef logic [NPAR-1:0][SYMW-1:0] par_t;
    typedef logic [CWW-1:0]           depth_t;

    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAR, ST_OUT} enc_state_e;

    typedef struct packed {
        logic [HDRW-1:0] hdr;
        logic [PAYW-1:0] pay;
    } block_t;

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYMW; i++) begin
            if (b[i]) acc ^= sh;
            sh = {sh[SYMW-2:0], 1'b0} ^ (sh[SYMW-1] ? FLD_LOW : '0);
        end
        return acc;
    endfunction

    // product of (x + alpha^r) for r = 0 .. NPAR-1, coefficient k at index k
    function automatic gen_t gen_poly();
        gen_t g;
        sym_t root;
        g    = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int r = 0; r < NPAR; r++) begin
            for (int k = NPAR; k > 0; k--)
                g[k] = g[k-1] ^ gf_mul(g[k], root);
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, sym_t'(2));
        end
        return g;
    endfunction

    localparam gen_t GEN = gen_poly();

    function automatic depth_t depth_decode(logic [1:0] cfg);
        case (cfg)
            2'd2:    return depth_t'(2);
            2'd3:    return depth_t'(3);
            default: return depth_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/rsenc_parity.sv
module rsenc_parity
    import rsenc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic shift_en,
    input  sym_t din,
    output par_t par
);

    sym_t fb;
    par_t nxt;

    always_comb begin
        fb     = din ^ par[NPAR-1];
        nxt[0] = gf_mul(fb, GEN[0]);
        for (int k = 1; k < NPAR; k++)
            nxt[k] = par[k-1] ^ gf_mul(fb, GEN[k]);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            par <= '0;
        else if (shift_en)
            par <= nxt;
    end

    // R3: remainder must not move while parity symbols are read out
    a_r3_parity_frozen: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clear) |=> $stable(par));

endmodule

// File: rtl/rsenc_ilv_store.sv
module rsenc_ilv_store
    import rsenc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  depth_t          wr_cw,
    input  logic [IDXW-1:0] wr_idx,
    input  sym_t            wr_sym,
    input  logic            rd_en,
    input  depth_t          rd_depth,
    input  depth_t          rd_frm,
    output logic [FRMW-1:0] rd_frame
);

    sym_t mem [MAXD][NSYM];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_cw][wr_idx] <= wr_sym;
    end

    // lane j of frame f carries line symbol NSYM*f + j
    for (genvar j = 0; j < NSYM; j++) begin : g_lane
        int   lin;
        int   cw;
        int   pos;
        sym_t lane_sym;
        always_comb begin
            lin = NSYM * int'(rd_frm) + j;
            case (rd_depth)
                depth_t'(2): begin cw = lin % 2; pos = lin / 2; end
                depth_t'(3): begin cw = lin % 3; pos = lin / 3; end
                default:     begin cw = 0;       pos = lin;     end
            endcase
            if (pos >= NSYM) pos = 0;
            lane_sym = mem[cw[CWW-1:0]][pos[IDXW-1:0]];
        end
        assign rd_frame[FRMW-1-SYMW*j -: SYMW] = lane_sym;
    end

    // R5: only frames that belong to the buffered group are read
    a_r5_frame_in_group: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_frm < rd_depth));

endmodule

// File: rtl/rsenc_frame_enc.sv
module rsenc_frame_enc
    import rsenc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [PAYW-1:0] in_payload,
    input  logic            in_btype,
    input  logic [1:0]      cfg_depth,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [FRMW-1:0] out_frame
);

    enc_state_e      state;
    logic [BLKW-1:0] blk_sr;
    logic [IDXW-1:0] sym_idx;
    depth_t          grp_depth;
    depth_t          cw_cnt;
    depth_t          frm_idx;
    par_t            par;
    block_t          new_blk;
    sym_t            wr_sym;
    logic [IDXW-1:0] pfull;
    logic            accept;
    logic            wr_en;

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_OUT);
    assign accept    = in_valid && in_ready;
    assign wr_en     = (state == ST_DATA) || (state == ST_PAR);

    always_comb begin
        new_blk.hdr = in_btype ? 2'b10 : 2'b01;
        new_blk.pay = in_payload;
    end

    assign pfull  = IDXW'(NSYM - 1) - sym_idx;
    assign wr_sym = (state == ST_DATA) ? blk_sr[BLKW-1 -: SYMW] : par[pfull[PIDXW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            blk_sr    <= '0;
            sym_idx   <= '0;
            cw_cnt    <= '0;
            frm_idx   <= '0;
            grp_depth <= depth_t'(1);
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        blk_sr  <= new_blk;
                        sym_idx <= '0;
                        state   <= ST_DATA;
                        if (cw_cnt == '0)
                            grp_depth <= depth_decode(cfg_depth);
                    end
                end
                ST_DATA: begin
                    blk_sr  <= blk_sr << SYMW;
                    sym_idx <= sym_idx + 1'b1;
                    if (sym_idx == IDXW'(KSYM - 1))
                        state <= ST_PAR;
                end
                ST_PAR: begin
                    sym_idx <= sym_idx + 1'b1;
                    if (sym_idx == IDXW'(NSYM - 1)) begin
                        sym_idx <= '0;
                        cw_cnt  <= cw_cnt + 1'b1;
                        if (depth_t'(cw_cnt + 1'b1) == grp_depth) begin
                            state   <= ST_OUT;
                            frm_idx <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    if (out_ready) begin
                        if (frm_idx == depth_t'(grp_depth - 1'b1)) begin
                            state   <= ST_IDLE;
                            cw_cnt  <= '0;
                            frm_idx <= '0;
                        end else begin
                            frm_idx <= frm_idx + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    rsenc_parity u_parity (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .shift_en (state == ST_DATA),
        .din      (blk_sr[BLKW-1 -: SYMW]),
        .par      (par)
    );

    rsenc_ilv_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_cw    (cw_cnt),
        .wr_idx   (sym_idx),
        .wr_sym   (wr_sym),
        .rd_en    (out_valid),
        .rd_depth (grp_depth),
        .rd_frm   (frm_idx),
        .rd_frame (out_frame)
    );

    // R9: a stalled frame stays on the port unchanged
    a_r9_frame_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_frame)));

    // R7: output starts only once every codeword of the group is stored
    a_r7_group_full: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (cw_cnt == grp_depth));

    // R8: depth is fixed except at the start of a group
    a_r8_depth_hold: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_IDLE && cw_cnt == '0) |=> $stable(grp_depth));

endmodule

// File: tb/tb_rsenc_frame_enc.sv
`timescale 1ns/1ps
module tb_rsenc_frame_enc;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_btype;
    logic [127:0] in_payload;
    logic [1:0]   cfg_depth;
    logic         out_ready;
    logic         in_ready;
    logic         out_valid;
    logic [149:0] out_frame;

    always #2.5 clk = ~clk;

    rsenc_frame_enc dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_payload (in_payload),
        .in_btype   (in_btype),
        .cfg_depth  (cfg_depth),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_frame  (out_frame)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    int frames_exp = 0;
    int frames_got = 0;
    bit stall_en = 0;
    bit done = 0;

    int alog [0:30];
    int glog [0:31];
    int gpoly [0:4];

    logic [149:0] exp_q [$];
    string        tag_q [$];
    int           dep_q [$];
    logic [129:0] blk_q [$];

    int           grp_cw  [0:2][0:29];
    logic [129:0] grp_blk [0:2];
    int           grp_n = 0;
    int           grp_d = 1;
    bit           grp_chg = 0;

    function automatic int gmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return alog[(glog[a] + glog[b]) % 31];
    endfunction

    function automatic int dec_depth(int d);
        if (d == 2) return 2;
        if (d == 3) return 3;
        return 1;
    endfunction

    task automatic init_field();
        int a;
        int nxt [0:4];
        a = 1;
        for (int i = 0; i < 31; i++) begin
            alog[i] = a;
            glog[a] = i;
            a = a << 1;
            if ((a & 32) != 0) a = a ^ 37;
        end
        for (int k = 0; k < 5; k++) gpoly[k] = 0;
        gpoly[0] = 1;
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 5; k++)
                nxt[k] = gmul(gpoly[k], alog[r]) ^ ((k > 0) ? gpoly[k-1] : 0);
            for (int k = 0; k < 5; k++) gpoly[k] = nxt[k];
        end
    endtask

    task automatic encode_into(input int slot, input logic [129:0] blk);
        int b [0:29];
        for (int i = 0; i < 26; i++) begin
            b[i] = int'(blk[129-5*i -: 5]);
            grp_cw[slot][i] = b[i];
        end
        for (int i = 26; i < 30; i++) b[i] = 0;
        for (int i = 0; i < 26; i++) begin
            int c;
            c = b[i];
            if (c != 0)
                for (int k = 0; k < 5; k++) b[i+k] = b[i+k] ^ gmul(c, gpoly[4-k]);
        end
        for (int i = 26; i < 30; i++) grp_cw[slot][i] = b[i];
    endtask

    task automatic model_accept(input logic [127:0] pay, input logic bt, input int dep);
        logic [129:0] blk;
        logic [149:0] fr;
        blk = {(bt ? 2'b10 : 2'b01), pay};
        if (grp_n == 0) begin
            grp_d   = dec_depth(dep);
            grp_chg = 0;
        end else if (dec_depth(dep) != grp_d) begin
            grp_chg = 1;
        end
        encode_into(grp_n, blk);
        grp_blk[grp_n] = blk;
        grp_n++;
        if (grp_n == grp_d) begin
            for (int f = 0; f < grp_d; f++) begin
                for (int j = 0; j < 30; j++) begin
                    int k;
                    k = 30 * f + j;
                    fr[149-5*j -: 5] = 5'(grp_cw[k % grp_d][k / grp_d]);
                end
                exp_q.push_back(fr);
                tag_q.push_back(grp_chg ? "R8" : (grp_d == 1 ? "R4" : (grp_d == 2 ? "R5" : "R6")));
                dep_q.push_back(grp_d);
                blk_q.push_back(grp_blk[f]);
                frames_exp++;
            end
            grp_n = 0;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [149:0] act, input logic [149:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [127:0] pay, input logic bt, input int dep);
        @(posedge clk);
        #1;
        in_valid   = 1'b1;
        in_payload = pay;
        in_btype   = bt;
        cfg_depth  = 2'(dep);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        model_accept(pay, bt, dep);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    always @(posedge clk) begin
        #1;
        out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    end

    // per-cycle comparison against the reference queue
    logic [149:0] held;
    bit           hold_chk = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_chk)
                check(out_valid && (out_frame == held), "R9", "stalled frame", out_frame, held);
            hold_chk = out_valid && !out_ready;
            held     = out_frame;
            if (out_valid && out_ready) begin
                frames_got++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "frame with no complete group", out_frame, '0);
                end else begin
                    logic [149:0] e;
                    logic [129:0] bk;
                    string        tg;
                    int           dp;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    dp = dep_q.pop_front();
                    bk = blk_q.pop_front();
                    check(out_frame == e, tg, "frame", out_frame, e);
                    if (dp == 1) begin
                        check(out_frame[149:148] == bk[129:128], "R1", "header",
                              150'(out_frame[149:148]), 150'(bk[129:128]));
                        check(out_frame[149:20] == bk, "R2", "data symbols",
                              150'(out_frame[149:20]), 150'(bk));
                        for (int r = 0; r < 4; r++) begin
                            int s;
                            s = 0;
                            for (int i = 0; i < 30; i++)
                                s = gmul(s, alog[r]) ^ int'(out_frame[149-5*i -: 5]);
                            check(s == 0, "R3", "syndrome", 150'(s), '0);
                        end
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual %0d expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        init_field();
        rst        = 1'b1;
        in_valid   = 1'b0;
        in_btype   = 1'b0;
        in_payload = '0;
        cfg_depth  = 2'd1;
        out_ready  = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R10", "in_ready after reset", 150'(in_ready), 150'(1));
        check(out_valid == 1'b0, "R10", "out_valid after reset", 150'(out_valid), '0);

        // depth 1: extreme and structured payloads
        send('0, 1'b0, 1);
        send('1, 1'b1, 1);
        send(128'h1 << 37, 1'b0, 0);
        for (int i = 0; i < 4; i++) send(rnd128(), 1'($urandom), 1);

        // two-way groups under back-pressure
        stall_en = 1;
        for (int i = 0; i < 4; i++) send(rnd128(), 1'($urandom), 2);

        // three-way groups, burst spreading
        for (int i = 0; i < 6; i++) send(rnd128(), 1'($urandom), 3);

        // R7: a partial group must stay inside
        send(rnd128(), 1'b1, 3);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7", "partial group output", 150'(out_valid), '0);
        end
        // R8: depth changed mid-group is ignored
        send(rnd128(), 1'b0, 1);
        send(rnd128(), 1'b1, 2);
        send(rnd128(), 1'b0, 2);
        send(rnd128(), 1'b1, 3);
        send(rnd128(), 1'b1, 1);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        // R11: nothing lost or duplicated
        check(frames_got == frames_exp, "R11", "frame count", 150'(frames_got), 150'(frames_exp));
        check(grp_n == 0, "R11", "open group in bench", 150'(grp_n), '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule